// File: doc/BRIEF.md
# Factory/Application Image Recovery Controller

This block decides which configuration image a device loads next and brings it back to a known-good factory image when the running application image fails. The factory image programs a 39-bit control word through a parallel write port. That word holds the application image address, the watchdog timeout, the watchdog enable, the early-done check enable and a startup oscillator select. When user logic in factory mode asks for a reconfiguration, the block issues a one-cycle request with the application boot address and enters application mode.

While the application runs, the block watches five conditions: a CRC error strobe, an external error strobe, a reconfiguration request from user logic, expiry of a user watchdog, and a failed early-done check. The early-done check fails when the done indication arrives before the image size has been fully loaded, or when the image is flagged invalid. Any of these conditions issues a reconfiguration request to boot address zero and returns the block to factory mode. A one-hot status word records the cause until the factory image reads it. Flash, bitstream and configuration pins are modelled as input strobes.

Top module: `img_recovery_ctrl`

## Requirements
- R1: After reset the block is in factory mode. `reconfig_req` is 0 and `status` is 0. `ctrl_word` reads 39'h78_0000_0000: timeout field 0, address field 0, bit 34 = 0, bits 35 (watchdog enable), 36 (oscillator select), 37 (early-done check) and 38 all 1.
- R2: In factory mode, a `cfg_wr_en` cycle loads `cfg_wr_data` into the control word. The fields are: timeout in bits 11:0, image address in bits 33:12, watchdog enable in bit 35, oscillator select in bit 36, early-done enable in bit 37. A write made in application mode leaves the control word unchanged.
- R3: A `user_reconfig` strobe in factory mode produces a pulse on `reconfig_req` on the next cycle. With that pulse, `boot_addr` equals {address field, 2'b00} and `app_mode` becomes 1.
- R4: In application mode, a CRC error, an external error, a user request, a watchdog expiry or an early-done failure each produce a pulse on `reconfig_req` on the next cycle. With that pulse, `boot_addr` is 0 and `app_mode` becomes 0.
- R5: `reconfig_req` is high for exactly one cycle, and `boot_addr_vld` is high with it. Trigger inputs seen during the pulse cycle are ignored.
- R6: The watchdog terminal count is the 29-bit value {timeout field, 17'd8}. The counter runs only in application mode with the enable bit set. It restarts from 0 on every reconfiguration. The expiry pulse appears terminal+1 cycles after the counter was last cleared (9 cycles for a field of 0).
- R7: A `wd_kick` cycle clears the watchdog counter. With the enable bit at 0, the watchdog never triggers.
- R8: With early-done enabled, an application-mode cycle in which `done_seen` is high and `load_complete` is low, or in which `img_invalid` is high, triggers the fallback. If `load_complete` is high with `done_seen`, or the enable bit is 0, there is no effect.
- R9: `status` is one-hot: bit 0 CRC, bit 1 external error, bit 2 user request, bit 3 watchdog, bit 4 early-done. When several causes arrive together, the lowest bit wins. The bit is visible in the same cycle as the pulse.
- R10: `status` holds its value until a `stat_rd` cycle in factory mode, which clears it to 0.
- R11: In factory mode, the CRC, external error, done and invalid strobes have no effect.
- R12: `startup_osc_int` follows bit 36 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 39 | Control word write value |
| wd_kick | input | 1 | Watchdog clear strobe |
| user_reconfig | input | 1 | Reconfiguration request from user logic |
| crc_err | input | 1 | CRC error strobe |
| ext_err | input | 1 | External error-status strobe |
| done_seen | input | 1 | Done indication observed |
| load_complete | input | 1 | Expected image size has been loaded |
| img_invalid | input | 1 | Image flagged invalid |
| stat_rd | input | 1 | Status read strobe (clears in factory mode) |
| ctrl_word | output | 39 | Current control word |
| app_mode | output | 1 | 1 while the application image runs |
| startup_osc_int | output | 1 | Internal startup oscillator select |
| reconfig_req | output | 1 | One-cycle reconfiguration request |
| boot_addr_vld | output | 1 | Boot address valid flag |
| boot_addr | output | 24 | Selected boot address |
| status | output | 5 | One-hot reconfiguration cause |

## Verification
On every cycle, the assertions check these rules:
- the request pulse never lasts two cycles;
- a return to factory mode always carries address zero;
- no pulse is raised in factory mode without a user request;
- the control word is frozen in application mode;
- the watchdog counter stays within its terminal count and clears on a kick;
- the status word stays one-hot or zero.

Only the bench scenarios can show the following:
- the exact expiry latency of the watchdog;
- that an application-mode write really had no effect on a later launch address;
- the cause priority when strobes coincide;
- that the status word survives until it is read.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
   // reconfiguration cause indices; lower index has priority
   localparam int CAUSE_CRC   = 0;
   localparam int CAUSE_EXT   = 1;
   localparam int CAUSE_USER  = 2;
   localparam int CAUSE_WDOG  = 3;
   localparam int CAUSE_EARLY = 4;
   localparam int NCAUSE      = 5;

   typedef enum logic {
      MODE_FACTORY = 1'b0,
      MODE_APP     = 1'b1
   } run_mode_e;

   // isolate the lowest set bit of a cause vector
   function automatic logic [NCAUSE-1:0] lowest_set(input logic [NCAUSE-1:0] v);
      return v & (~v + NCAUSE'(1));
   endfunction
endpackage

// File: rtl/rcu_ctrl_reg.sv
module rcu_ctrl_reg #(
   parameter int WD_FIELD_W   = 12,
   parameter int ADDR_FIELD_W = 22,
   parameter int CTRL_W       = WD_FIELD_W + ADDR_FIELD_W + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_lock,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] q
);
   localparam logic [CTRL_W-1:0] RST_VAL =
      {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, {ADDR_FIELD_W{1'b0}}, {WD_FIELD_W{1'b0}}};

   generate
      if (CTRL_W != WD_FIELD_W + ADDR_FIELD_W + 5) begin : g_bad_width
         $error("rcu_ctrl_reg: CTRL_W must equal field widths plus five flag bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (wr_en && !wr_lock)
         q <= wr_data;
   end

   // R2
   ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lock |=> $stable(q));
endmodule

// File: rtl/rcu_watchdog.sv
module rcu_watchdog #(
   parameter int FIELD_W = 12,
   parameter int PAD_W   = 17,
   parameter int PAD_VAL = 8,
   parameter int CNT_W   = FIELD_W + PAD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               kick,
   input  logic               restart,
   input  logic [FIELD_W-1:0] field,
   output logic               expired
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;

   generate
      if (PAD_W < 1 || PAD_W > 30) begin : g_bad_pad_w
         $error("rcu_watchdog: PAD_W out of range");
      end
      if (PAD_VAL < 1 || PAD_VAL >= (1 << PAD_W)) begin : g_bad_pad_val
         $error("rcu_watchdog: PAD_VAL must be nonzero and fit PAD_W bits");
      end
      if (CNT_W != FIELD_W + PAD_W) begin : g_bad_cnt_w
         $error("rcu_watchdog: CNT_W must equal FIELD_W + PAD_W");
      end
   endgenerate

   assign term    = {field, PAD_W'(PAD_VAL)};
   assign expired = run && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || kick || !run)
         cnt_q <= '0;
      else if (cnt_q != term)
         cnt_q <= cnt_q + CNT_W'(1);
   end

   // R6
   wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= term));
   // R7
   wd_kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cnt_q == '0));
endmodule

// File: rtl/rcu_status.sv
module rcu_status #(
   parameter int NBITS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [NBITS-1:0] cause,
   input  logic             clear,
   output logic [NBITS-1:0] status
);
   generate
      if (NBITS < 1) begin : g_bad_nbits
         $error("rcu_status: NBITS must be positive");
      end
      for (genvar i = 0; i < NBITS; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               status[i] <= 1'b0;
            else if (capture)
               status[i] <= cause[i];
            else if (clear)
               status[i] <= 1'b0;
         end
      end
   endgenerate

   // R9
   status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(status));
   // R10
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !capture) |=> (status == '0));
   // R10
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !capture) |=> $stable(status));
endmodule

// File: rtl/img_recovery_ctrl.sv
module img_recovery_ctrl import rcu_pkg::*; #(
   parameter int WD_FIELD_W   = 12,
   parameter int WD_PAD_W     = 17,
   parameter int WD_PAD_VAL   = 8,
   parameter int ADDR_FIELD_W = 22,
   parameter int ADDR_SHIFT   = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_wr_en,
   input  logic [WD_FIELD_W+ADDR_FIELD_W+4:0] cfg_wr_data,
   input  logic                               wd_kick,
   input  logic                               user_reconfig,
   input  logic                               crc_err,
   input  logic                               ext_err,
   input  logic                               done_seen,
   input  logic                               load_complete,
   input  logic                               img_invalid,
   input  logic                               stat_rd,
   output logic [WD_FIELD_W+ADDR_FIELD_W+4:0] ctrl_word,
   output logic                               app_mode,
   output logic                               startup_osc_int,
   output logic                               reconfig_req,
   output logic                               boot_addr_vld,
   output logic [ADDR_FIELD_W+ADDR_SHIFT-1:0] boot_addr,
   output logic [NCAUSE-1:0]                  status
);
   localparam int CTRL_W    = WD_FIELD_W + ADDR_FIELD_W + 5;
   localparam int ADDR_W    = ADDR_FIELD_W + ADDR_SHIFT;
   localparam int ADDR_LSB  = WD_FIELD_W;
   localparam int WDEN_BIT  = ADDR_LSB + ADDR_FIELD_W + 1;
   localparam int OSC_BIT   = WDEN_BIT + 1;
   localparam int EARLY_BIT = OSC_BIT + 1;

   generate
      if (ADDR_SHIFT < 0 || ADDR_SHIFT > 8) begin : g_bad_shift
         $error("img_recovery_ctrl: ADDR_SHIFT out of range");
      end
   endgenerate

   run_mode_e                 mode_q;
   logic                      req_q;
   logic [ADDR_W-1:0]         addr_q;
   logic [CTRL_W-1:0]         ctrl_q;
   logic [WD_FIELD_W-1:0]     wd_field;
   logic [ADDR_FIELD_W-1:0]   img_addr;
   logic                      wd_en, early_en;
   logic                      in_app, accept;
   logic                      wd_expired, early_fail;
   logic [NCAUSE-1:0]         raw_cause, win_cause;
   logic                      launch, abort;

   rcu_ctrl_reg #(
      .WD_FIELD_W   (WD_FIELD_W),
      .ADDR_FIELD_W (ADDR_FIELD_W),
      .CTRL_W       (CTRL_W)
   ) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_lock (in_app),
      .wr_data (cfg_wr_data),
      .q       (ctrl_q)
   );

   assign wd_field = ctrl_q[WD_FIELD_W-1:0];
   assign img_addr = ctrl_q[ADDR_LSB +: ADDR_FIELD_W];
   assign wd_en    = ctrl_q[WDEN_BIT];
   assign early_en = ctrl_q[EARLY_BIT];

   assign in_app = (mode_q == MODE_APP);
   assign accept = !req_q;

   rcu_watchdog #(
      .FIELD_W (WD_FIELD_W),
      .PAD_W   (WD_PAD_W),
      .PAD_VAL (WD_PAD_VAL)
   ) wdog_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (in_app && wd_en),
      .kick    (wd_kick),
      .restart (launch || abort),
      .field   (wd_field),
      .expired (wd_expired)
   );

   assign early_fail = early_en && ((done_seen && !load_complete) || img_invalid);

   always_comb begin
      raw_cause              = '0;
      raw_cause[CAUSE_CRC]   = crc_err;
      raw_cause[CAUSE_EXT]   = ext_err;
      raw_cause[CAUSE_USER]  = user_reconfig;
      raw_cause[CAUSE_WDOG]  = wd_expired;
      raw_cause[CAUSE_EARLY] = early_fail;
      if (!(in_app && accept))
         raw_cause = '0;
   end

   assign win_cause = lowest_set(raw_cause);
   assign abort     = |raw_cause;
   assign launch    = !in_app && accept && user_reconfig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_FACTORY;
         req_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         req_q <= launch || abort;
         if (launch) begin
            mode_q <= MODE_APP;
            addr_q <= {img_addr, {ADDR_SHIFT{1'b0}}};
         end else if (abort) begin
            mode_q <= MODE_FACTORY;
            addr_q <= '0;
         end
      end
   end

   rcu_status #(
      .NBITS (NCAUSE)
   ) stat_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (abort),
      .cause   (win_cause),
      .clear   (stat_rd && !in_app),
      .status  (status)
   );

   assign ctrl_word       = ctrl_q;
   assign app_mode        = in_app;
   assign startup_osc_int = ctrl_q[OSC_BIT];
   assign reconfig_req    = req_q;
   assign boot_addr_vld   = req_q;
   assign boot_addr       = addr_q;

   // R5
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reconfig_req |=> !reconfig_req);
   // R4
   fallback_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reconfig_req && !app_mode) |-> (boot_addr == '0));
   // R11
   factory_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!app_mode && !user_reconfig) |=> !reconfig_req);
   // R3
   launch_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reconfig_req && app_mode) |-> $past(!app_mode));
endmodule

// File: tb/img_recovery_ctrl_tb.sv
`timescale 1ns/1ps
module img_recovery_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr_en, wd_kick, user_reconfig, crc_err, ext_err;
   logic        done_seen, load_complete, img_invalid, stat_rd;
   logic [38:0] cfg_wr_data;
   logic [38:0] ctrl_word;
   logic        app_mode, startup_osc_int, reconfig_req, boot_addr_vld;
   logic [23:0] boot_addr;
   logic [4:0]  status;

   int nchk  = 0;
   int nfail = 0;

   typedef struct {
      logic [23:0] addr;
      logic        app;
      logic [4:0]  st;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   always #2 clk = ~clk;

   img_recovery_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .wd_kick(wd_kick), .user_reconfig(user_reconfig), .crc_err(crc_err),
      .ext_err(ext_err), .done_seen(done_seen), .load_complete(load_complete),
      .img_invalid(img_invalid), .stat_rd(stat_rd), .ctrl_word(ctrl_word),
      .app_mode(app_mode), .startup_osc_int(startup_osc_int),
      .reconfig_req(reconfig_req), .boot_addr_vld(boot_addr_vld),
      .boot_addr(boot_addr), .status(status)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [38:0] mk_ctrl(input logic [21:0] a, input logic [11:0] f,
                                           input logic we, input logic osc, input logic cd);
      return {1'b1, cd, osc, we, 1'b0, a, f};
   endfunction

   task automatic push_exp(input logic [23:0] a, input logic app, input logic [4:0] st, input string tag);
      exp_t e;
      e.addr = a; e.app = app; e.st = st; e.tag = tag;
      sbq.push_back(e);
   endtask

   // strobe mask: 0 crc,1 ext,2 user,3 kick,4 done,5 invalid,6 stat_rd,7 load_complete
   task automatic fire(input logic [7:0] m, input int n = 1);
      crc_err = m[0]; ext_err = m[1]; user_reconfig = m[2]; wd_kick = m[3];
      done_seen = m[4]; img_invalid = m[5]; stat_rd = m[6]; load_complete = m[7];
      repeat (n) @(negedge clk);
      crc_err = 0; ext_err = 0; user_reconfig = 0; wd_kick = 0;
      done_seen = 0; img_invalid = 0; stat_rd = 0; load_complete = 0;
   endtask

   task automatic wr(input logic [38:0] d);
      cfg_wr_en = 1'b1; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic drained(input string tag);
      @(negedge clk);
      chk(sbq.size() == 0, tag, sbq.size(), 0);
   endtask

   task automatic launch(input logic [23:0] a, input string tag);
      push_exp(a, 1'b1, 5'b0, tag);
      fire(8'h04);
      drained(tag);
   endtask

   task automatic read_clear();
      fire(8'h40);
      chk(status == 5'b0, "R10", status, 0);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      exp_t e;
      if (rst_n === 1'b1 && reconfig_req === 1'b1) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R5 unexpected pulse", boot_addr, 0);
         end else begin
            e = sbq.pop_front();
            chk(boot_addr == e.addr, e.tag, boot_addr, e.addr);
            chk(boot_addr_vld == 1'b1, "R5", boot_addr_vld, 1);
            chk(app_mode == e.app, e.tag, app_mode, e.app);
            chk(status == e.st, e.tag, status, e.st);
         end
      end
   end

   initial begin
      #800000;
      chk(1'b0, "watchdog timeout", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      int n;
      rst_n = 0; cfg_wr_en = 0; cfg_wr_data = '0;
      wd_kick = 0; user_reconfig = 0; crc_err = 0; ext_err = 0;
      done_seen = 0; load_complete = 0; img_invalid = 0; stat_rd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(app_mode == 0, "R1", app_mode, 0);
      chk(reconfig_req == 0, "R1", reconfig_req, 0);
      chk(status == 0, "R1", status, 0);
      chk(ctrl_word == 39'h78_0000_0000, "R1", ctrl_word, 39'h78_0000_0000);
      chk(startup_osc_int == 1, "R12", startup_osc_int, 1);

      // R2 factory write, R12 oscillator bit
      wr(mk_ctrl(22'h12345, 12'h0, 1'b1, 1'b0, 1'b1));
      chk(ctrl_word == mk_ctrl(22'h12345, 12'h0, 1'b1, 1'b0, 1'b1), "R2", ctrl_word,
          mk_ctrl(22'h12345, 12'h0, 1'b1, 1'b0, 1'b1));
      chk(startup_osc_int == 0, "R12", startup_osc_int, 0);

      // R3 launch, then R2 ignored write, R7 kicks, R6 expiry latency
      launch(24'h048D14, "R3");
      wr(mk_ctrl(22'h3FFFFF, 12'hABC, 1'b0, 1'b1, 1'b0));
      chk(ctrl_word == mk_ctrl(22'h12345, 12'h0, 1'b1, 1'b0, 1'b1), "R2", ctrl_word,
          mk_ctrl(22'h12345, 12'h0, 1'b1, 1'b0, 1'b1));
      fire(8'h08);
      for (int k = 0; k < 8; k++) begin
         repeat (3) @(negedge clk);
         fire(8'h08);
      end
      chk(app_mode == 1, "R7", app_mode, 1);
      push_exp(24'h0, 1'b0, 5'b01000, "R6");
      n = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         n++;
         if (reconfig_req) break;
      end
      chk(n == 9, "R6", n, 9);
      chk(status == 5'b01000, "R9", status, 5'b01000);
      repeat (3) @(negedge clk);
      chk(status == 5'b01000, "R10", status, 5'b01000);
      read_clear();

      // R11 factory ignores error strobes
      fire(8'h33);
      @(negedge clk);
      chk(app_mode == 0, "R11", app_mode, 0);
      chk(status == 0, "R11", status, 0);
      drained("R11");

      // R2 the application-mode write had no effect on the launch address
      launch(24'h048D14, "R2");
      push_exp(24'h0, 1'b0, 5'b00001, "R4");
      fire(8'h01);
      read_clear();

      // R9 priority: crc and ext together
      launch(24'h048D14, "R3");
      push_exp(24'h0, 1'b0, 5'b00001, "R9");
      fire(8'h03);
      read_clear();

      launch(24'h048D14, "R3");
      push_exp(24'h0, 1'b0, 5'b00010, "R4");
      fire(8'h02);
      read_clear();

      launch(24'h048D14, "R3");
      push_exp(24'h0, 1'b0, 5'b00100, "R4");
      fire(8'h04);
      read_clear();

      // R8 early done and invalid image
      launch(24'h048D14, "R3");
      push_exp(24'h0, 1'b0, 5'b10000, "R8");
      fire(8'h10);
      read_clear();
      launch(24'h048D14, "R3");
      push_exp(24'h0, 1'b0, 5'b10000, "R8");
      fire(8'h20);
      read_clear();
      launch(24'h048D14, "R3");
      fire(8'h90);
      repeat (2) @(negedge clk);
      chk(app_mode == 1, "R8", app_mode, 1);
      push_exp(24'h0, 1'b0, 5'b00100, "R4");
      fire(8'h04);
      read_clear();

      // R5 request held two cycles gives one pulse
      push_exp(24'h048D14, 1'b1, 5'b0, "R5");
      fire(8'h04, 2);
      chk(reconfig_req == 0, "R5", reconfig_req, 0);
      drained("R5");
      chk(app_mode == 1, "R5", app_mode, 1);
      push_exp(24'h0, 1'b0, 5'b00001, "R4");
      fire(8'h01);
      read_clear();

      // R7 watchdog disabled, R8 early check disabled
      wr(mk_ctrl(22'h00001, 12'h0, 1'b0, 1'b1, 1'b0));
      launch(24'h000004, "R3");
      repeat (30) @(negedge clk);
      chk(app_mode == 1, "R7", app_mode, 1);
      fire(8'h20);
      @(negedge clk);
      chk(app_mode == 1, "R8", app_mode, 1);
      push_exp(24'h0, 1'b0, 5'b00100, "R4");
      fire(8'h04);
      read_clear();
      drained("R4");

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule